// File: doc/BRIEF.md
# Direct-Mapped Write-Through Byte Cache

This block sits between a byte-addressed requester and a slower memory that returns whole blocks. Each request address is split into a tag, a set index and a byte offset. Every set holds exactly one line, made of a valid flag, a stored tag and one data block. A read that finds a valid line with a matching tag is answered from the line. Any other read fetches the whole block from memory, overwrites the line, and then answers with the requested byte.

Writes always go through to memory. A write that hits also patches the cached byte. A write that misses leaves every line as it was. Two counters report how many accepted accesses hit and how many missed.

Both request channels use valid/ready. The requester holds `cpu_req_valid` and its fields stable until `cpu_req_ready` is seen high at a clock edge. `cpu_req_ready` is high only when no access is in flight. The response is a one-cycle pulse on `cpu_resp_valid` with no back-pressure, so the requester must take it in that cycle. Toward memory, the cache holds the block-read request and the write request, with their address and data, stable until the matching ready is sampled high. After a block-read handshake, memory returns the block with a one-cycle `mem_rd_resp_valid` pulse, which may come any number of cycles later.

Top module: `dm_wt_cache`

## Requirements
- R1: The request address is split, from least significant upward, into OFF_W offset bits, IDX_W set-index bits and the remaining tag bits. With the default parameters, bit 0 is the offset, bits 2:1 are the set and bit 3 is the tag.
- R2: After reset all lines are invalid, both counters are zero, `cpu_resp_valid` and both memory request valids are low, and `cpu_req_ready` is high. The first access to any set is therefore a miss.
- R3: A read hit needs a valid line whose stored tag equals the address tag. It answers in the cycle after acceptance with `cpu_resp_hit`=1 and the byte at the offset within the line, and it makes no memory request.
- R4: A read miss raises a block-read request with address `addr >> OFF_W`. When the block returns, it is written into the line and the response follows one cycle later with `cpu_resp_hit`=0 and the addressed byte of the returned block.
- R5: A read whose set holds a valid line with a different tag evicts that line, and the new block replaces it.
- R6: With the default widths, byte reads of addresses 0, 1, 7, 8, 0 from reset give miss, hit, miss, miss, miss.
- R7: A write hit updates the cached byte and also issues one memory write of that byte to the same address. Its response has `cpu_resp_hit`=1.
- R8: A write miss issues one memory write and loads or changes no line, so a later read of a different tag in that set behaves as before. Its response has `cpu_resp_hit`=0.
- R9: `cpu_req_ready` is low from the acceptance of a miss or a write until its response, and back-to-back read hits are accepted one per cycle.
- R10: `hit_count` and `miss_count` each increase by one for every accepted access (read or write) that hits or misses, respectively.
- R11: Under memory back-pressure, a pending block-read or write request keeps its valid, address and data unchanged until its ready is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Request valid |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | 8 | Write byte |
| cpu_resp_valid | output | 1 | One-cycle response pulse |
| cpu_resp_rdata | output | 8 | Read byte (write byte echoed on writes) |
| cpu_resp_hit | output | 1 | Access hit the cache |
| mem_rd_req_valid | output | 1 | Block-read request valid |
| mem_rd_req_ready | input | 1 | Memory accepts block-read request |
| mem_rd_addr | output | ADDR_W-OFF_W | Block address |
| mem_rd_resp_valid | input | 1 | Returned block valid (one cycle) |
| mem_rd_resp_data | input | 8*2^OFF_W | Returned block, byte 0 in the low bits |
| mem_wr_valid | output | 1 | Byte-write request valid |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Byte address of the write |
| mem_wr_data | output | 8 | Byte to write |
| hit_count | output | CNT_W | Accesses that hit |
| miss_count | output | CNT_W | Accesses that missed |

## Verification
The main function is driven with a fixed list of reads and writes. The list opens with the five-read trace, so that the cold miss, the spatial hit on the neighbouring byte and the tag-conflict evictions in set 0 can each be told apart. Write hits and write misses follow, each paired with later reads. Those reads show whether the cached byte changed, whether memory took the write, and whether a missing write wrongly allocated a line by displacing the older block. Memory back-pressure of zero to two cycles varies from vector to vector, which separates a correct held request from one that drops or shifts its address. A reset in the middle of the run shows that lines filled before reset no longer hit.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_WAIT = 2'd2,
    ST_WR      = 2'd3
  } cache_st_e;
endpackage

// File: rtl/dm_tag_store.sv
module dm_tag_store #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else if (fill_en && (fill_idx == IDX_W'(g))) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= fill_tag;
      end
    end
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  // R4: a filled set is valid with the new tag on the next cycle
  p_fill_sets_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(fill_idx)] && (tag_q[$past(fill_idx)] == $past(fill_tag)));
endmodule

// File: rtl/dm_data_store.sv
module dm_data_store #(
  parameter int IDX_W = 2,
  parameter int OFF_W = 1
) (
  input  logic                              clk,
  input  logic [IDX_W-1:0]                  rd_idx,
  input  logic [OFF_W-1:0]                  rd_off,
  output logic [dm_cache_pkg::BYTE_W-1:0]   rd_byte,
  input  logic                              fill_en,
  input  logic [IDX_W-1:0]                  fill_idx,
  input  logic [(dm_cache_pkg::BYTE_W<<OFF_W)-1:0] fill_blk,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [OFF_W-1:0]                  wr_off,
  input  logic [dm_cache_pkg::BYTE_W-1:0]   wr_byte
);
  import dm_cache_pkg::*;
  localparam int SETS  = 1 << IDX_W;
  localparam int BLK_W = BYTE_W << OFF_W;

  logic [BLK_W-1:0] blk_q [SETS];
  logic [BLK_W-1:0] rd_blk;

  for (genvar g = 0; g < SETS; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (fill_en && (fill_idx == IDX_W'(g)))
        blk_q[g] <= fill_blk;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        blk_q[g][BYTE_W*int'(wr_off) +: BYTE_W] <= wr_byte;
    end
  end

  assign rd_blk  = blk_q[rd_idx];
  assign rd_byte = rd_blk[BYTE_W*int'(rd_off) +: BYTE_W];
endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl #(
  parameter int ADDR_W = 4,
  parameter int OFF_W  = 1,
  parameter int CNT_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_req_valid,
  output logic                         cpu_req_ready,
  input  logic                         cpu_req_write,
  input  logic [ADDR_W-1:0]            cpu_req_addr,
  input  logic [dm_cache_pkg::BYTE_W-1:0] cpu_req_wdata,
  output logic                         cpu_resp_valid,
  output logic [dm_cache_pkg::BYTE_W-1:0] cpu_resp_rdata,
  output logic                         cpu_resp_hit,
  input  logic                         lk_hit,
  input  logic [dm_cache_pkg::BYTE_W-1:0] hit_byte,
  output logic                         fill_en,
  output logic [ADDR_W-1:0]            held_addr,
  output logic                         byte_we,
  output logic                         mem_rd_req_valid,
  input  logic                         mem_rd_req_ready,
  output logic [ADDR_W-OFF_W-1:0]      mem_rd_addr,
  input  logic                         mem_rd_resp_valid,
  input  logic [(dm_cache_pkg::BYTE_W<<OFF_W)-1:0] mem_rd_resp_data,
  output logic                         mem_wr_valid,
  input  logic                         mem_wr_ready,
  output logic [ADDR_W-1:0]            mem_wr_addr,
  output logic [dm_cache_pkg::BYTE_W-1:0] mem_wr_data,
  output logic [CNT_W-1:0]             hit_count,
  output logic [CNT_W-1:0]             miss_count
);
  import dm_cache_pkg::*;

  cache_st_e          st_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [BYTE_W-1:0]  wdata_q;
  logic               whit_q;
  logic [OFF_W-1:0]   off_q;
  logic               accept;

  assign cpu_req_ready    = (st_q == ST_IDLE);
  assign accept           = cpu_req_valid && cpu_req_ready;
  assign byte_we          = accept && cpu_req_write && lk_hit;
  assign fill_en          = (st_q == ST_RD_WAIT) && mem_rd_resp_valid;
  assign off_q            = addr_q[OFF_W-1:0];
  assign held_addr        = addr_q;
  assign mem_rd_req_valid = (st_q == ST_RD_REQ);
  assign mem_rd_addr      = addr_q[ADDR_W-1:OFF_W];
  assign mem_wr_valid     = (st_q == ST_WR);
  assign mem_wr_addr      = addr_q;
  assign mem_wr_data      = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q           <= ST_IDLE;
      addr_q         <= '0;
      wdata_q        <= '0;
      whit_q         <= 1'b0;
      cpu_resp_valid <= 1'b0;
      cpu_resp_rdata <= '0;
      cpu_resp_hit   <= 1'b0;
      hit_count      <= '0;
      miss_count     <= '0;
    end else begin
      cpu_resp_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q  <= cpu_req_addr;
            wdata_q <= cpu_req_wdata;
            whit_q  <= lk_hit;
            if (lk_hit) hit_count  <= hit_count + 1'b1;
            else        miss_count <= miss_count + 1'b1;
            if (cpu_req_write) begin
              st_q <= ST_WR;
            end else if (lk_hit) begin
              cpu_resp_valid <= 1'b1;
              cpu_resp_rdata <= hit_byte;
              cpu_resp_hit   <= 1'b1;
            end else begin
              st_q <= ST_RD_REQ;
            end
          end
        end
        ST_RD_REQ: begin
          if (mem_rd_req_ready) st_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (mem_rd_resp_valid) begin
            cpu_resp_valid <= 1'b1;
            cpu_resp_rdata <= mem_rd_resp_data[BYTE_W*int'(off_q) +: BYTE_W];
            cpu_resp_hit   <= 1'b0;
            st_q           <= ST_IDLE;
          end
        end
        ST_WR: begin
          if (mem_wr_ready) begin
            cpu_resp_valid <= 1'b1;
            cpu_resp_rdata <= wdata_q;
            cpu_resp_hit   <= whit_q;
            st_q           <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R11: block-read request held under back-pressure
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req_valid && !mem_rd_req_ready |=> mem_rd_req_valid && $stable(mem_rd_addr));

  // R11: write request held under back-pressure
  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  // R4: returned block produces a miss response on the next cycle
  p_fill_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> cpu_resp_valid && !cpu_resp_hit && cpu_req_ready);

  // R9: a memory transaction in progress blocks new requests
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req_valid || mem_wr_valid) |-> !cpu_req_ready);

  // R10: the two counters together advance by at most one per cycle
  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (({1'b0, hit_count} + {1'b0, miss_count})
              - $past({1'b0, hit_count} + {1'b0, miss_count})) <= (CNT_W+1)'(1));
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int ADDR_W = 4,
  parameter int OFF_W  = 1,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_req_valid,
  output logic                         cpu_req_ready,
  input  logic                         cpu_req_write,
  input  logic [ADDR_W-1:0]            cpu_req_addr,
  input  logic [7:0]                   cpu_req_wdata,
  output logic                         cpu_resp_valid,
  output logic [7:0]                   cpu_resp_rdata,
  output logic                         cpu_resp_hit,
  output logic                         mem_rd_req_valid,
  input  logic                         mem_rd_req_ready,
  output logic [ADDR_W-OFF_W-1:0]      mem_rd_addr,
  input  logic                         mem_rd_resp_valid,
  input  logic [(8<<OFF_W)-1:0]        mem_rd_resp_data,
  output logic                         mem_wr_valid,
  input  logic                         mem_wr_ready,
  output logic [ADDR_W-1:0]            mem_wr_addr,
  output logic [7:0]                   mem_wr_data,
  output logic [CNT_W-1:0]             hit_count,
  output logic [CNT_W-1:0]             miss_count
);
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int IDX_LSB = OFF_W;
  localparam int TAG_LSB = OFF_W + IDX_W;

  logic              lk_hit;
  logic [7:0]        hit_byte;
  logic              fill_en;
  logic              byte_we;
  logic [ADDR_W-1:0] held_addr;

  // R1: field split of the request and held addresses
  logic [OFF_W-1:0] req_off,  held_off;
  logic [IDX_W-1:0] req_idx,  held_idx;
  logic [TAG_W-1:0] req_tag,  held_tag;

  assign req_off  = cpu_req_addr[OFF_W-1:0];
  assign req_idx  = cpu_req_addr[IDX_LSB +: IDX_W];
  assign req_tag  = cpu_req_addr[TAG_LSB +: TAG_W];
  assign held_off = held_addr[OFF_W-1:0];
  assign held_idx = held_addr[IDX_LSB +: IDX_W];
  assign held_tag = held_addr[TAG_LSB +: TAG_W];

  dm_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (req_idx),
    .lk_tag   (req_tag),
    .lk_hit   (lk_hit),
    .fill_en  (fill_en),
    .fill_idx (held_idx),
    .fill_tag (held_tag)
  );

  dm_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
    .clk      (clk),
    .rd_idx   (req_idx),
    .rd_off   (req_off),
    .rd_byte  (hit_byte),
    .fill_en  (fill_en),
    .fill_idx (held_idx),
    .fill_blk (mem_rd_resp_data),
    .wr_en    (byte_we),
    .wr_idx   (req_idx),
    .wr_off   (req_off),
    .wr_byte  (cpu_req_wdata)
  );

  dm_cache_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .cpu_req_valid     (cpu_req_valid),
    .cpu_req_ready     (cpu_req_ready),
    .cpu_req_write     (cpu_req_write),
    .cpu_req_addr      (cpu_req_addr),
    .cpu_req_wdata     (cpu_req_wdata),
    .cpu_resp_valid    (cpu_resp_valid),
    .cpu_resp_rdata    (cpu_resp_rdata),
    .cpu_resp_hit      (cpu_resp_hit),
    .lk_hit            (lk_hit),
    .hit_byte          (hit_byte),
    .fill_en           (fill_en),
    .held_addr         (held_addr),
    .byte_we           (byte_we),
    .mem_rd_req_valid  (mem_rd_req_valid),
    .mem_rd_req_ready  (mem_rd_req_ready),
    .mem_rd_addr       (mem_rd_addr),
    .mem_rd_resp_valid (mem_rd_resp_valid),
    .mem_rd_resp_data  (mem_rd_resp_data),
    .mem_wr_valid      (mem_wr_valid),
    .mem_wr_ready      (mem_wr_ready),
    .mem_wr_addr       (mem_wr_addr),
    .mem_wr_data       (mem_wr_data),
    .hit_count         (hit_count),
    .miss_count        (miss_count)
  );

  // R8: the held offset is only meaningful for misses; keep it observed
  logic unused_off;
  assign unused_off = ^held_off;
endmodule

// File: tb/dm_wt_cache_bench.sv
module dm_wt_cache_bench;
  localparam int ADDR_W = 4;
  localparam int OFF_W  = 1;
  localparam int IDX_W  = 2;
  localparam int CNT_W  = 16;
  localparam int NV     = 15;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic [7:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_resp_valid, cpu_resp_hit;
  logic [7:0] cpu_resp_rdata;
  logic mem_rd_req_valid, mem_wr_valid;
  logic mem_rd_req_ready = 1'b0, mem_rd_resp_valid = 1'b0, mem_wr_ready = 1'b0;
  logic [ADDR_W-OFF_W-1:0] mem_rd_addr;
  logic [15:0] mem_rd_resp_data = '0;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic [7:0] mem_wr_data;
  logic [CNT_W-1:0] hit_count, miss_count;

  dm_wt_cache #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dm_wt_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_resp_valid(cpu_resp_valid),
    .cpu_resp_rdata(cpu_resp_rdata), .cpu_resp_hit(cpu_resp_hit),
    .mem_rd_req_valid(mem_rd_req_valid), .mem_rd_req_ready(mem_rd_req_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rd_resp_valid(mem_rd_resp_valid),
    .mem_rd_resp_data(mem_rd_resp_data), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .hit_count(hit_count), .miss_count(miss_count)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int stall = 0;
  int rd_cnt = 0, wr_cnt = 0;
  int last_rd_blk = -1, last_wr_addr = -1, last_wr_data = -1;
  logic [7:0] mem [16];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Memory model: bounded stall before each ready, block returned after the read handshake
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'hA0 + 8'(i);
    forever begin
      @(negedge clk);
      if (mem_rd_req_valid) begin
        repeat (stall) @(negedge clk);
        last_rd_blk = int'(mem_rd_addr);
        mem_rd_req_ready = 1'b1;
        @(negedge clk);
        mem_rd_req_ready = 1'b0;
        mem_rd_resp_data = {mem[2*last_rd_blk+1], mem[2*last_rd_blk]};
        mem_rd_resp_valid = 1'b1;
        rd_cnt++;
        @(negedge clk);
        mem_rd_resp_valid = 1'b0;
      end else if (mem_wr_valid) begin
        repeat (stall) @(negedge clk);
        last_wr_addr = int'(mem_wr_addr);
        last_wr_data = int'(mem_wr_data);
        mem[mem_wr_addr] = mem_wr_data;
        mem_wr_ready = 1'b1;
        wr_cnt++;
        @(negedge clk);
        mem_wr_ready = 1'b0;
      end
    end
  end

  // One access; checks hit flag, data, latency and memory traffic
  task automatic access(input bit wr, input logic [3:0] addr, input logic [7:0] wd,
                        input bit exp_hit, input logic [7:0] exp_d, input string req);
    int rd0, wr0, cyc;
    rd0 = rd_cnt; wr0 = wr_cnt; cyc = 0;
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = addr; cpu_req_wdata = wd;
    chk(cpu_req_ready === 1'b1, {req, " ready before accept (R9)"}, int'(cpu_req_ready), 1);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (cpu_resp_valid !== 1'b1 && cyc < 50) begin
      if (cyc == 0)
        chk(cpu_req_ready === 1'b0, {req, " ready low while pending (R9)"}, int'(cpu_req_ready), 0);
      @(negedge clk);
      cyc++;
    end
    chk(cpu_resp_hit === exp_hit, {req, " hit flag"}, int'(cpu_resp_hit), int'(exp_hit));
    if (!wr) chk(cpu_resp_rdata === exp_d, {req, " read data"}, int'(cpu_resp_rdata), int'(exp_d));
    if (!wr && exp_hit) begin
      chk(cyc == 0, {req, " hit latency (R3)"}, cyc, 0);
      chk(rd_cnt == rd0 && wr_cnt == wr0, {req, " no memory traffic on hit (R3)"}, rd_cnt - rd0, 0);
    end
    if (!wr && !exp_hit) begin
      chk(rd_cnt == rd0 + 1, {req, " one block read (R4)"}, rd_cnt - rd0, 1);
      chk(last_rd_blk == int'(addr >> 1), {req, " block address (R1)"}, last_rd_blk, int'(addr >> 1));
    end
    if (wr) begin
      chk(wr_cnt == wr0 + 1 && rd_cnt == rd0, {req, " single memory write"}, wr_cnt - wr0, 1);
      chk(last_wr_addr == int'(addr) && last_wr_data == int'(wd), {req, " write addr/data"},
          last_wr_data, int'(wd));
    end
    @(negedge clk);
  endtask

  // {write, addr[3:0], wdata[7:0], exp_hit, exp_data[7:0]}; memory starts as A0+address
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 4'h0, 8'h00, 1'b0, 8'hA0},
    {1'b0, 4'h1, 8'h00, 1'b1, 8'hA1},
    {1'b0, 4'h7, 8'h00, 1'b0, 8'hA7},
    {1'b0, 4'h8, 8'h00, 1'b0, 8'hA8},
    {1'b0, 4'h0, 8'h00, 1'b0, 8'hA0},
    {1'b1, 4'h1, 8'h55, 1'b1, 8'h00},
    {1'b0, 4'h1, 8'h00, 1'b1, 8'h55},
    {1'b1, 4'h5, 8'h66, 1'b0, 8'h00},
    {1'b0, 4'h5, 8'h00, 1'b0, 8'h66},
    {1'b0, 4'h4, 8'h00, 1'b1, 8'hA4},
    {1'b1, 4'hE, 8'h77, 1'b0, 8'h00},
    {1'b0, 4'h7, 8'h00, 1'b1, 8'hA7},
    {1'b0, 4'hE, 8'h00, 1'b0, 8'h77},
    {1'b0, 4'h8, 8'h00, 1'b0, 8'hA8},
    {1'b0, 4'h1, 8'h00, 1'b0, 8'h55}
  };

  initial begin
    int eh, em;
    string tag;
    eh = 0; em = 0;
    repeat (4) @(negedge clk);
    // R2: reset state
    chk(cpu_req_ready === 1'b1 && cpu_resp_valid === 1'b0, "R2 reset handshake", int'(cpu_resp_valid), 0);
    chk(mem_rd_req_valid === 1'b0 && mem_wr_valid === 1'b0, "R2 reset mem idle", int'(mem_rd_req_valid), 0);
    chk(hit_count == 0 && miss_count == 0, "R2 reset counters", int'(hit_count + miss_count), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      stall = i % 3;
      if (i < 5) tag = "R6 trace";
      else if (VEC[i][21] && VEC[i][8]) tag = "R7 write hit";
      else if (VEC[i][21]) tag = "R8 write miss";
      else if (VEC[i][8]) tag = "R3 read hit";
      else tag = "R4 R5 read miss";
      access(VEC[i][21], VEC[i][20:17], VEC[i][16:9], VEC[i][8], VEC[i][7:0],
             $sformatf("%s vec%0d", tag, i));
      if (VEC[i][8]) eh++; else em++;
      chk(int'(hit_count) == eh && int'(miss_count) == em, $sformatf("R10 counters vec%0d", i),
          int'(hit_count), eh);
    end

    // R2: reset in the middle drops all lines and counters
    stall = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(hit_count == 0 && miss_count == 0 && cpu_req_ready === 1'b1, "R2 counters after mid reset",
        int'(hit_count + miss_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b0, 4'h1, 8'h00, 1'b0, 8'h55, "R2 cold miss after reset");
    access(1'b0, 4'h0, 8'h00, 1'b1, 8'hA0, "R3 neighbour hit after refill");
    chk(hit_count == 1 && miss_count == 1, "R10 counters after reset run", int'(hit_count), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule